// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block sits between a CPU data-access port and a slower single-word memory bus and is invisible to software. Every cacheable read is looked up in a one-way cache. The line is chosen by the index bits of the address, and the stored tag plus a per-line valid bit decide whether the access hits. A read hit returns in the cycle it is presented. A read miss first fetches the whole aligned line, one word at a time, and then answers from the cache.

Each stored word keeps the error status its fill transfer returned. A line whose fill partly failed stays valid, and only an access to one of its failed words reports an error. Writes go through to memory every time, and a write hit also patches the cached copy. Addresses whose top nibble is 0xF form a pass-through window for memory-mapped IO: they are never looked up or allocated. A clear pulse, issued when the CPU executes a fence, drops every line so that later reads reload from memory.

Top module: `dcache_dm`

## Requirements
- R1: After reset every line is invalid, `cpuReady` and `memReq` are low, and the first cacheable read misses.
- R2: A read to a cacheable address whose indexed line is valid with a matching tag raises `cpuReady` in the same cycle as the request, with the stored word, and starts no memory transfer.
- R3: A cacheable read miss issues LINE_BYTES/4 single-word memory reads, all four byte enables set, at ascending word addresses from the line-aligned base, then answers with the requested word.
- R4: The address splits into word offset (bits below log2(LINE_BYTES)), line index (the next log2(NUM_LINES) bits) and tag (the rest). Two lines with equal index and different tags evict each other, and lines with different index coexist.
- R5: Every filled word stores its own bus-error flag, and the line is marked valid even when some words failed. A later hit on a failed word sets `cpuErr` with `cpuReady`, and a hit on a clean word of the same line does not.
- R6: An access with address 0xF0000000 to 0xFFFFFFFF performs exactly one memory transfer with the CPU's address, direction, data and byte enables, and forwards its data and error flag. Nothing is allocated, so repeating it transfers again.
- R7: Every write, cached or not, performs one memory write with the CPU's address, data and byte enables. `cpuReady` rises on that transfer's acknowledge, and `cpuErr` copies its error flag.
- R8: A cacheable write that hits and returns no error updates only the byte lanes enabled in `cpuBe` (bit n enables bits 8n+7..8n) of the cached word. A write miss allocates nothing.
- R9: A `clearReq` pulse while no transfer is in progress invalidates all lines. It takes priority over a request present in the same cycle, which then misses and refills.
- R10: `memReq` and `memAddr` hold until `memAck`. `cpuReady` rises only while `cpuReq` is high, and `cpuErr` rises only together with `cpuReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | CPU access request, held until the edge where cpuReady is high |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Byte address (word aligned) |
| cpuWdata | input | 32 | Write data |
| cpuBe | input | 4 | Byte enables, bit n for byte lane n |
| cpuRdata | output | 32 | Read data, valid with cpuReady |
| cpuReady | output | 1 | Access complete this cycle |
| cpuErr | output | 1 | Access completed with a bus error |
| clearReq | input | 1 | One-cycle pulse that invalidates all lines |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | Memory transfer is a write |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memBe | output | 4 | Memory byte enables |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | One-cycle transfer acknowledge |
| memErr | input | 1 | Transfer error, valid with memAck |

## Verification
The properties assume a well-behaved CPU and memory. The CPU keeps `cpuReq`, address, data and enables steady from the request through the clock edge at which `cpuReady` is sampled high, and releases the request just after that edge. The memory answers each request with exactly one single-cycle `memAck`. `clearReq` pulses only between accesses. The directed tasks drive the CPU side in exactly that pattern, and the bench memory model acknowledges each request once after a fixed wait and stays silent in the cycle after.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  // Top address nibble that marks the uncached IO window.
  localparam logic [3:0] IO_NIBBLE = 4'hF;

  // Strobes from control to storage.
  typedef struct packed {
    logic fillWe;    // store one fetched word and its error flag
    logic fillDone;  // set valid and tag of the indexed line
    logic wrHit;     // merge write data into the hit word
    logic clearAll;  // drop every valid bit
  } cacheStrobe_t;

  function automatic logic inIoWindow(input logic [31:0] addr);
    return addr[31:28] == IO_NIBBLE;
  endfunction

endpackage

// File: rtl/dcache_store.sv
module dcache_store
  import dcache_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 4,
  localparam int WORDS = LINE_BYTES / 4,
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  cacheStrobe_t       strb,
  input  logic [29:0]        wordAddr,
  input  logic [31:0]        cpuWdata,
  input  logic [3:0]         cpuBe,
  input  logic [CNT_W-1:0]   fillCnt,
  input  logic [31:0]        memRdata,
  input  logic               memErr,
  output logic               hit,
  output logic               hitErr,
  output logic [31:0]        rdWord
);

  localparam int WOFF_W   = $clog2(WORDS);
  localparam int IDX_BITS = $clog2(NUM_LINES);
  localparam int TAG_W    = 30 - WOFF_W - IDX_BITS;
  localparam int LIDX_W   = (NUM_LINES > 1) ? IDX_BITS : 1;
  localparam int ENTRIES  = NUM_LINES * WORDS;
  localparam int EIDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TAG_W-1:0]   tagMem  [NUM_LINES];
  logic [31:0]        wordMem [ENTRIES];
  logic [ENTRIES-1:0] wordErr;
  logic [NUM_LINES-1:0] lineValid;

  logic [LIDX_W-1:0] lineIdx;
  logic [CNT_W-1:0]  wordSel;
  logic [TAG_W-1:0]  reqTag;
  logic [EIDX_W-1:0] rdEntry;
  logic [EIDX_W-1:0] fillEntry;

  // Field extraction; narrow variants when a field has no bits.
  if (NUM_LINES > 1) begin : g_index
    assign lineIdx = wordAddr[WOFF_W +: IDX_BITS];
  end else begin : g_noIndex
    assign lineIdx = '0;
  end

  if (WORDS > 1) begin : g_offset
    assign wordSel = wordAddr[0 +: WOFF_W];
  end else begin : g_noOffset
    assign wordSel = '0;
  end

  assign reqTag    = wordAddr[29 -: TAG_W];
  assign rdEntry   = EIDX_W'(32'(lineIdx) * 32'(WORDS) + 32'(wordSel));
  assign fillEntry = EIDX_W'(32'(lineIdx) * 32'(WORDS) + 32'(fillCnt));

  assign hit    = lineValid[lineIdx] && (tagMem[lineIdx] == reqTag);
  assign hitErr = wordErr[rdEntry];
  assign rdWord = wordMem[rdEntry];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineValid <= '0;
    end else if (strb.clearAll) begin
      lineValid <= '0;
    end else if (strb.fillDone) begin
      lineValid[lineIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillDone) begin
      tagMem[lineIdx] <= reqTag;
    end
    if (strb.fillWe) begin
      wordMem[fillEntry] <= memRdata;
      wordErr[fillEntry] <= memErr;
    end
    if (strb.wrHit) begin
      for (int lane = 0; lane < 4; lane++) begin
        if (cpuBe[lane]) begin
          wordMem[rdEntry][8*lane +: 8] <= cpuWdata[8*lane +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  localparam int WORDS = LINE_BYTES / 4,
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuWe,
  input  logic [31:0]      cpuAddr,
  input  logic [31:0]      cpuWdata,
  input  logic [3:0]       cpuBe,
  input  logic             clearReq,
  input  logic             hit,
  input  logic             hitErr,
  input  logic [31:0]      rdWord,
  output logic             cpuReady,
  output logic             cpuErr,
  output logic [31:0]      cpuRdata,
  output logic             memReq,
  output logic             memWe,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWdata,
  output logic [3:0]       memBe,
  input  logic [31:0]      memRdata,
  input  logic             memAck,
  input  logic             memErr,
  output logic [CNT_W-1:0] fillCnt,
  output cacheStrobe_t     strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FILL} ctrlState_t;

  ctrlState_t state, stateNext;
  logic [CNT_W-1:0] fillCntNext;
  logic             ioAccess;
  logic [31:0]      lineBase;
  logic             lastWord;

  assign ioAccess = inIoWindow(cpuAddr);
  assign lineBase = cpuAddr & ~(32'(LINE_BYTES) - 32'd1);
  assign lastWord = (fillCnt == CNT_W'(WORDS - 1));

  always_comb begin
    stateNext   = state;
    fillCntNext = fillCnt;
    strb        = '0;
    cpuReady    = 1'b0;
    cpuErr      = 1'b0;
    cpuRdata    = '0;
    memReq      = 1'b0;
    memWe       = 1'b0;
    memAddr     = cpuAddr;
    memWdata    = cpuWdata;
    memBe       = cpuBe;
    unique case (state)
      ST_IDLE: begin
        if (clearReq) begin
          strb.clearAll = 1'b1;
        end else if (cpuReq) begin
          if (cpuWe || ioAccess) begin
            stateNext = ST_XFER;
          end else if (hit) begin
            cpuReady = 1'b1;
            cpuErr   = hitErr;
            cpuRdata = rdWord;
          end else begin
            stateNext   = ST_FILL;
            fillCntNext = '0;
          end
        end
      end
      ST_XFER: begin
        memReq = 1'b1;
        memWe  = cpuWe;
        if (memAck) begin
          cpuReady   = 1'b1;
          cpuErr     = memErr;
          cpuRdata   = memRdata;
          strb.wrHit = cpuWe && !ioAccess && hit && !memErr;
          stateNext  = ST_IDLE;
        end
      end
      ST_FILL: begin
        memReq   = 1'b1;
        memBe    = 4'hF;
        memWdata = '0;
        memAddr  = lineBase | (32'(fillCnt) << 2);
        if (memAck) begin
          strb.fillWe = 1'b1;
          if (lastWord) begin
            strb.fillDone = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            fillCntNext = fillCnt + 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fillCnt <= '0;
    end else begin
      state   <= stateNext;
      fillCnt <= fillCntNext;
    end
  end

endmodule

// File: rtl/dcache_dm.sv
module dcache_dm
  import dcache_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic [31:0] cpuAddr,
  input  logic [31:0] cpuWdata,
  input  logic [3:0]  cpuBe,
  output logic [31:0] cpuRdata,
  output logic        cpuReady,
  output logic        cpuErr,
  input  logic        clearReq,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [3:0]  memBe,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  input  logic        memErr
);

  localparam int WORDS = LINE_BYTES / 4;
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_badLine
    $error("LINE_BYTES must be a power of two of at least 4");
  end
  if (NUM_LINES < 1 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_badCount
    $error("NUM_LINES must be a power of two of at least 1");
  end

  cacheStrobe_t     strb;
  logic [CNT_W-1:0] fillCnt;
  logic             hit;
  logic             hitErr;
  logic [31:0]      rdWord;

  dcache_ctrl #(.LINE_BYTES(LINE_BYTES)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .cpuBe    (cpuBe),
    .clearReq (clearReq),
    .hit      (hit),
    .hitErr   (hitErr),
    .rdWord   (rdWord),
    .cpuReady (cpuReady),
    .cpuErr   (cpuErr),
    .cpuRdata (cpuRdata),
    .memReq   (memReq),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memBe    (memBe),
    .memRdata (memRdata),
    .memAck   (memAck),
    .memErr   (memErr),
    .fillCnt  (fillCnt),
    .strb     (strb)
  );

  dcache_store #(.LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)) store (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wordAddr (cpuAddr[31:2]),
    .cpuWdata (cpuWdata),
    .cpuBe    (cpuBe),
    .fillCnt  (fillCnt),
    .memRdata (memRdata),
    .memErr   (memErr),
    .hit      (hit),
    .hitErr   (hitErr),
    .rdWord   (rdWord)
  );

endmodule

// File: rtl/dcache_dm_chk.sv
module dcache_dm_chk #(
  parameter int LINE_BYTES = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        cpuReq,
  input logic        cpuWe,
  input logic [31:0] cpuAddr,
  input logic        cpuReady,
  input logic        cpuErr,
  input logic        clearReq,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [3:0]  memBe,
  input logic        memAck
);

  localparam logic [31:0] LINE_MASK = ~(32'(LINE_BYTES) - 32'd1);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr));

  // R10
  ready_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq);

  // R10
  err_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuErr |-> cpuReady);

  // R6
  io_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAddr[31:28] == 4'hF |-> memAddr == cpuAddr && memWe == cpuWe);

  // R7
  write_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady && cpuWe |-> memAck && memWe && memAddr == cpuAddr);

  // R3
  fill_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memAddr[31:28] != 4'hF |->
      memBe == 4'hF && memAddr[1:0] == 2'b00 &&
      (memAddr & LINE_MASK) == (cpuAddr & LINE_MASK));

  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady && !cpuWe && cpuAddr[31:28] != 4'hF && !memAck |-> !memReq);

  // R9
  clear_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(clearReq) && cpuReq && !cpuWe && cpuAddr[31:28] != 4'hF |-> !cpuReady);

endmodule

bind dcache_dm dcache_dm_chk #(.LINE_BYTES(LINE_BYTES)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuWe    (cpuWe),
  .cpuAddr  (cpuAddr),
  .cpuReady (cpuReady),
  .cpuErr   (cpuErr),
  .clearReq (clearReq),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memBe    (memBe),
  .memAck   (memAck)
);

// File: tb/dcache_dm_test.sv
`timescale 1ns/1ps
module dcache_dm_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [3:0]  cpuBe = 4'hF;
  logic [31:0] cpuRdata;
  logic        cpuReady;
  logic        cpuErr;
  logic        clearReq = 1'b0;
  logic        memReq;
  logic        memWe;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic [3:0]  memBe;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        memErr = 1'b0;

  always #4 clk = ~clk;

  dcache_dm uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuBe(cpuBe), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .cpuErr(cpuErr), .clearReq(clearReq), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .memRdata(memRdata),
    .memAck(memAck), .memErr(memErr)
  );

  int checks = 0;
  int fails  = 0;

  // Memory model: 1024 words, acknowledges after a fixed wait, on falling edges.
  logic [31:0] mem [1024];
  logic [31:0] errAddr = 32'hFFFF_FFFC;
  int          readCnt = 0;
  int          writeCnt = 0;
  logic [31:0] readLog [16];
  logic [31:0] lastWAddr, lastWData;
  logic [3:0]  lastWBe;
  int          waitCnt = 0;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hD000_0000 | (32'(i) << 2);
  end

  always @(negedge clk) begin
    if (!rstN) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else if (memAck) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else if (memReq) begin
      if (waitCnt == 2) begin
        memAck   <= 1'b1;
        memErr   <= (memAddr == errAddr);
        memRdata <= mem[memAddr[11:2]];
        if (memWe) begin
          for (int b = 0; b < 4; b++)
            if (memBe[b]) mem[memAddr[11:2]][8*b +: 8] <= memWdata[8*b +: 8];
          lastWAddr <= memAddr;
          lastWData <= memWdata;
          lastWBe   <= memBe;
          writeCnt  <= writeCnt + 1;
        end else begin
          readLog[readCnt % 16] <= memAddr;
          readCnt <= readCnt + 1;
        end
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [31:0] rData;
  logic        rErr;
  int          rWait;

  // Waits for cpuReady with the request already driven; holds through the edge.
  task automatic waitReady();
    rWait = 0;
    forever begin
      #1;
      if (cpuReady) begin
        rData = cpuRdata;
        rErr  = cpuErr;
        @(posedge clk);
        #1;
        cpuReq = 1'b0;
        cpuWe  = 1'b0;
        break;
      end
      if (rWait > 200) begin
        check(1'b0, "R10 timeout", 32'(rWait), 32'd200);
        cpuReq = 1'b0;
        break;
      end
      rWait++;
      @(negedge clk);
    end
  endtask

  task automatic access(input logic [31:0] a, input bit we, input logic [31:0] wd, input logic [3:0] be);
    @(negedge clk);
    cpuAddr = a; cpuWe = we; cpuWdata = wd; cpuBe = be; cpuReq = 1'b1;
    waitReady();
  endtask

  task automatic readExpect(input logic [31:0] a, input int expReads, input bit expErr, input string tag);
    int r0;
    r0 = readCnt;
    access(a, 1'b0, '0, 4'hF);
    check(readCnt - r0 == expReads, {tag, " reads"}, 32'(readCnt - r0), 32'(expReads));
    check(rErr == expErr, {tag, " err"}, 32'(rErr), 32'(expErr));
    if (!expErr) check(rData == mem[a[11:2]], {tag, " data"}, rData, mem[a[11:2]]);
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
  endtask

  task automatic idleCheck();
    @(negedge clk);
    #1;
    check(!memReq && !cpuReady, "R10 idle quiet", {30'd0, memReq, cpuReady}, 32'd0);
  endtask

  task automatic testReset();
    #1;
    check(!cpuReady && !memReq, "R1 reset outputs", {30'd0, cpuReady, memReq}, 32'd0);
  endtask

  task automatic testMissFill();
    int r0;
    r0 = readCnt;
    readExpect(32'h0000_0108, 4, 1'b0, "R1 R3 first miss");
    for (int k = 0; k < 4; k++)
      check(readLog[(r0 + k) % 16] == 32'h100 + 32'(4 * k), "R3 fill order",
            readLog[(r0 + k) % 16], 32'h100 + 32'(4 * k));
  endtask

  task automatic testHit();
    readExpect(32'h0000_0104, 0, 1'b0, "R2 hit");
    check(rWait == 0, "R2 same cycle", 32'(rWait), 32'd0);
  endtask

  task automatic testConflict();
    readExpect(32'h0000_0200, 4, 1'b0, "R4 conflict load");
    readExpect(32'h0000_010C, 4, 1'b0, "R4 evicted refill");
    readExpect(32'h0000_0110, 4, 1'b0, "R4 other index");
    readExpect(32'h0000_0100, 0, 1'b0, "R4 coexist");
  endtask

  task automatic testWordErr();
    errAddr = 32'h0000_0304;
    readExpect(32'h0000_0300, 4, 1'b0, "R5 partial fill");
    readExpect(32'h0000_0304, 0, 1'b1, "R5 bad word");
    readExpect(32'h0000_0308, 0, 1'b0, "R5 clean word");
  endtask

  task automatic testIoWindow();
    int w0;
    errAddr = 32'hF000_0020;
    readExpect(32'hF000_0010, 1, 1'b0, "R6 io read");
    check(readLog[(readCnt - 1) % 16] == 32'hF000_0010, "R6 io addr",
          readLog[(readCnt - 1) % 16], 32'hF000_0010);
    readExpect(32'hF000_0010, 1, 1'b0, "R6 no allocate");
    readExpect(32'hF000_0020, 1, 1'b1, "R6 io error");
    w0 = writeCnt;
    access(32'hF000_0034, 1'b1, 32'h1234_5678, 4'b0100);
    check(writeCnt - w0 == 1, "R6 io write count", 32'(writeCnt - w0), 32'd1);
    check(lastWAddr == 32'hF000_0034 && lastWBe == 4'b0100 && lastWData == 32'h1234_5678,
          "R6 io write fields", lastWAddr, 32'hF000_0034);
  endtask

  task automatic testWrites();
    logic [31:0] oldV;
    int w0;
    int r0;
    readExpect(32'h0000_0114, 0, 1'b0, "R8 line present");
    oldV = rData;
    w0 = writeCnt;
    access(32'h0000_0114, 1'b1, 32'hAAAA_BBBB, 4'b0011);
    check(writeCnt - w0 == 1, "R7 write through", 32'(writeCnt - w0), 32'd1);
    check(lastWAddr == 32'h114 && lastWData == 32'hAAAA_BBBB && lastWBe == 4'b0011,
          "R7 write fields", lastWData, 32'hAAAA_BBBB);
    check(!rErr, "R7 write ok", 32'(rErr), 32'd0);
    r0 = readCnt;
    access(32'h0000_0114, 1'b0, '0, 4'hF);
    check(readCnt == r0, "R8 hit after write", 32'(readCnt - r0), 32'd0);
    check(rData == {oldV[31:16], 16'hBBBB}, "R8 lane merge", rData, {oldV[31:16], 16'hBBBB});
    access(32'h0000_0500, 1'b1, 32'h5A5A_0500, 4'hF);
    readExpect(32'h0000_0500, 4, 1'b0, "R8 no write allocate");
    check(rData == 32'h5A5A_0500, "R7 memory updated", rData, 32'h5A5A_0500);
  endtask

  task automatic testClear();
    int r0;
    readExpect(32'h0000_0110, 0, 1'b0, "R9 before clear");
    pulseClear();
    readExpect(32'h0000_0110, 4, 1'b0, "R9 reload after clear");
    r0 = readCnt;
    @(negedge clk);
    cpuAddr = 32'h0000_0118; cpuWe = 1'b0; cpuBe = 4'hF; cpuReq = 1'b1; clearReq = 1'b1;
    #1;
    check(!cpuReady, "R9 clear wins", 32'(cpuReady), 32'd0);
    @(posedge clk);
    #1;
    clearReq = 1'b0;
    @(negedge clk);
    waitReady();
    check(readCnt - r0 == 4, "R9 refill after priority", 32'(readCnt - r0), 32'd4);
    check(rData == mem[32'h118 >> 2], "R9 data", rData, mem[32'h118 >> 2]);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMissFill();
    testHit();
    testConflict();
    testWordErr();
    idleCheck();
    testIoWindow();
    testWrites();
    testClear();
    idleCheck();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule